// File: doc/BRIEF.md
# Double-Buffered Auxiliary DAC Code Register

This block holds the code for an auxiliary digital-to-analog converter. An upstream serial register decoder delivers byte writes: the code arrives as a low byte and a high byte at two neighbouring byte addresses, and both land first in a staging (holding) register. The DAC never sees the staging register directly. Only a write to a separate global command register with the transfer bit set copies the full staged code into the DAC input register in one clock edge. The DAC output therefore moves from one complete code to the next and never passes through a half-written value.

The code is 12 bits in offset binary, where 0 is 0 V and one step is roughly 0.806 mV, so 0x4D9 gives about 1 V. The staging register can be read back as a 16-bit word with the unused top four bits at zero. The transfer bit acts as a one-cycle strobe and always reads back as zero.

Top module: `auxdac_buffered`

## Requirements
- R1: While and after reset (rstN low, active low), the staged code and dacCode are both 0, and a staging readback returns 0x0000.
- R2: A write (wrEn high) to byte address 0x30 puts wrData[7:0] into staged bits [7:0] at the next clock edge; staged bits [11:8] and dacCode stay unchanged.
- R3: A write to byte address 0x31 puts wrData[3:0] into staged bits [11:8] at the next clock edge; wrData[7:4] are discarded, staged bits [7:0] and dacCode stay unchanged.
- R4: A write to byte address 0x3E with wrData[2] = 1 makes dacCode equal to the staged code, as it stood before that edge, from the next clock edge on.
- R5: A write to byte address 0x3E with wrData[2] = 0 leaves dacCode unchanged.
- R6: dacCode changes only on the edge that follows a transfer write; staging writes alone never move it.
- R7: A write to any byte address other than 0x30, 0x31 and 0x3E, or any cycle with wrEn low, changes neither the staged code nor dacCode.
- R8: With rdAddr at 0x30 or 0x31, rdData shows {4'b0000, staged code} combinationally; with rdAddr at 0x3E or any other address, rdData is 0x0000, so the transfer bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Byte write strobe from the register decoder |
| wrAddr | input | 7 | Byte address of the write |
| wrData | input | 8 | Byte value of the write |
| rdAddr | input | 7 | Byte address for readback |
| rdData | output | 16 | Readback word |
| dacCode | output | 12 | Code presented to the DAC input |

## Verification
Every write takes effect on the first rising edge that sees it: the staged code is visible on rdData and a transferred code on dacCode from that edge on, while rdData itself follows rdAddr with no register. The bench drives each write at a falling edge, lets one rising edge pass, and compares both outputs at the following falling edge against a model updated at that same rising edge. Readback is checked for both byte addresses, the command address and unrelated addresses in the same half-cycle window.

// File: rtl/auxdac_pkg.sv
package auxdac_pkg;

  // Strobes handed from the address decoder to the register datapath.
  typedef struct packed {
    logic wrLow;    // load staged low byte
    logic wrHigh;   // load staged high part
    logic latch;    // copy staged code into DAC input register
    logic rdHold;   // readback address selects the staged word
  } auxStrobes_t;

endpackage

// File: rtl/auxdac_ctrl.sv
module auxdac_ctrl
  import auxdac_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 7'h30,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 7'h31,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 7'h3E
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrLatchBit,
  input  logic [ADDR_W-1:0] rdAddr,
  output auxStrobes_t       strb
);

  logic hitLo;
  logic hitHi;
  logic hitCmd;

  always_comb begin
    hitLo  = (wrAddr == LO_ADDR);
    hitHi  = (wrAddr == HI_ADDR);
    hitCmd = (wrAddr == CMD_ADDR);
  end

  always_comb begin
    strb        = '0;
    strb.wrLow  = wrEn && hitLo;
    strb.wrHigh = wrEn && hitHi;
    strb.latch  = wrEn && hitCmd && wrLatchBit;
    strb.rdHold = (rdAddr == LO_ADDR) || (rdAddr == HI_ADDR);
  end

endmodule

// File: rtl/auxdac_datapath.sv
module auxdac_datapath
  import auxdac_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12,
  parameter int RD_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobes_t       strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CODE_W-1:0] holdCode,
  output logic [CODE_W-1:0] dacCode,
  output logic [RD_W-1:0]   rdData
);

  localparam int HI_W  = CODE_W - BYTE_W;
  localparam int PAD_W = RD_W - CODE_W;

  logic [BYTE_W-1:0] holdLo;
  logic [HI_W-1:0]   holdHi;
  logic [CODE_W-1:0] dacQ;

  // Staging register, low byte lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdLo <= '0;
    else if (strb.wrLow) holdLo <= wrData;
  end

  // Staging register, high lane; byte bits above the code are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdHi <= '0;
    else if (strb.wrHigh) holdHi <= wrData[HI_W-1:0];
  end

  assign holdCode = {holdHi, holdLo};

  // DAC input register, loaded only on the transfer strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dacQ <= '0;
    else if (strb.latch) dacQ <= holdCode;
  end

  assign dacCode = dacQ;

  always_comb begin
    if (strb.rdHold) rdData = {{PAD_W{1'b0}}, holdCode};
    else             rdData = '0;
  end

endmodule

// File: rtl/auxdac_buffered.sv
module auxdac_buffered
  import auxdac_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int BYTE_W    = 8,
  parameter int CODE_W    = 12,
  parameter int LATCH_BIT = 2,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 7'h30,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 7'h31,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 7'h3E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [2*BYTE_W-1:0] rdData,
  output logic [CODE_W-1:0] dacCode
);

  localparam int RD_W = 2 * BYTE_W;

  auxStrobes_t       strb;
  logic [CODE_W-1:0] holdValue;

  auxdac_ctrl #(
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR),
    .CMD_ADDR(CMD_ADDR)
  ) ctrlInst (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrLatchBit(wrData[LATCH_BIT]),
    .rdAddr    (rdAddr),
    .strb      (strb)
  );

  auxdac_datapath #(
    .BYTE_W(BYTE_W),
    .CODE_W(CODE_W),
    .RD_W  (RD_W)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .holdCode(holdValue),
    .dacCode (dacCode),
    .rdData  (rdData)
  );

endmodule

// File: rtl/auxdac_chk.sv
module auxdac_chk #(
  parameter int ADDR_W    = 7,
  parameter int BYTE_W    = 8,
  parameter int CODE_W    = 12,
  parameter int LATCH_BIT = 2,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 7'h30,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 7'h31,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 7'h3E
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic [CODE_W-1:0] holdValue,
  input logic [CODE_W-1:0] dacCode
);

  localparam int HI_W = CODE_W - BYTE_W;

  logic seenLo, seenHi, seenLatch;
  assign seenLo    = rstN && wrEn && (wrAddr == LO_ADDR);
  assign seenHi    = rstN && wrEn && (wrAddr == HI_ADDR);
  assign seenLatch = rstN && wrEn && (wrAddr == CMD_ADDR) && wrData[LATCH_BIT];

  // R2
  low_byte_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenLo |=> (holdValue[BYTE_W-1:0] == $past(wrData)) &&
               (holdValue[CODE_W-1:BYTE_W] == $past(holdValue[CODE_W-1:BYTE_W])));

  // R3
  high_part_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenHi |=> (holdValue[CODE_W-1:BYTE_W] == $past(wrData[HI_W-1:0])) &&
               (holdValue[BYTE_W-1:0] == $past(holdValue[BYTE_W-1:0])));

  // R4
  transfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenLatch |=> dacCode == $past(holdValue));

  // R6
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !seenLatch) |=> $stable(dacCode));

  // R7
  stage_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !seenLo && !seenHi) |=> $stable(holdValue));

endmodule

bind auxdac_buffered auxdac_chk #(
  .ADDR_W   (ADDR_W),
  .BYTE_W   (BYTE_W),
  .CODE_W   (CODE_W),
  .LATCH_BIT(LATCH_BIT),
  .LO_ADDR  (LO_ADDR),
  .HI_ADDR  (HI_ADDR),
  .CMD_ADDR (CMD_ADDR)
) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .holdValue(holdValue),
  .dacCode  (dacCode)
);

// File: tb/tb_auxdac_buffered.sv
`timescale 1ns/1ps
module tb_auxdac_buffered;

  localparam logic [6:0] A_LO  = 7'h30;
  localparam logic [6:0] A_HI  = 7'h31;
  localparam logic [6:0] A_CMD = 7'h3E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [6:0]  rdAddr = A_LO;
  logic [15:0] rdData;
  logic [11:0] dacCode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [11:0] expHold = '0;
  logic [11:0] expDac  = '0;

  always #2.5 clk = ~clk;

  auxdac_buffered dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .dacCode(dacCode)
  );

  function automatic logic [15:0] expRead(input logic [6:0] a, input logic [11:0] h);
    if (a == A_LO || a == A_HI) return {4'b0000, h};
    return 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one write cycle starting at a falling edge; model follows at the rising edge.
  task automatic doCycle(input logic en, input logic [6:0] a, input logic [7:0] d);
    wrEn = en; wrAddr = a; wrData = d;
    @(posedge clk);
    if (en && a == A_LO) expHold[7:0] = d;
    else if (en && a == A_HI) expHold[11:8] = d[3:0];
    else if (en && a == A_CMD && d[2]) expDac = expHold;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    check({tag, " dac"}, {4'b0, dacCode}, {4'b0, expDac});
    rdAddr = A_LO;
    #0.1 check({tag, " rd"}, rdData, expRead(rdAddr, expHold));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dac in reset", {4'b0, dacCode}, 16'h0);
    check("R1 rd in reset", rdData, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // Directed: the 1 V example
    doCycle(1, A_LO, 8'hD9); checkAll("R2 low byte");
    doCycle(1, A_HI, 8'h04); checkAll("R3 high part");
    check("R6 dac waits for transfer", {4'b0, dacCode}, 16'h0);
    doCycle(1, A_CMD, 8'h04); checkAll("R4 transfer");
    check("R4 code 1V", {4'b0, dacCode}, 16'h04D9);

    // R3 upper bits discarded
    doCycle(1, A_HI, 8'hFA); checkAll("R3 discard");
    rdAddr = A_HI; #0.1 check("R3 rd high addr", rdData, 16'h0AD9);

    // R5 command without transfer bit
    doCycle(1, A_CMD, 8'hFB); checkAll("R5 no-latch cmd");
    check("R5 dac kept", {4'b0, dacCode}, 16'h04D9);

    // R7 wrEn low with transfer pattern, and a foreign address
    doCycle(0, A_CMD, 8'h04); checkAll("R7 wrEn low");
    doCycle(1, 7'h32, 8'h55); checkAll("R7 other addr");

    // R8 command readback is zero, other address zero
    rdAddr = A_CMD; #0.1 check("R8 cmd reads 0", rdData, 16'h0);
    rdAddr = 7'h12; #0.1 check("R8 other reads 0", rdData, 16'h0);
    doCycle(1, A_CMD, 8'h04); checkAll("R4 second transfer");
    check("R4 code 0xAD9", {4'b0, dacCode}, 16'h0AD9);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 8;
      logic [6:0] a;
      logic en = ($urandom % 6) != 0;
      logic [7:0] d = 8'($urandom);
      if (sel < 3) a = A_LO;
      else if (sel < 5) a = A_HI;
      else if (sel < 7) a = A_CMD;
      else a = 7'($urandom);
      doCycle(en, a, d);
      checkAll("R6 random");
      rdAddr = 7'($urandom);
      #0.1 check("R8 random rd", rdData, expRead(rdAddr, expHold));
    end

    // R1 reset mid-run clears both registers
    rstN = 1'b0; expHold = '0; expDac = '0;
    #1 checkAll("R1 reset again");
    rstN = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule